// File: doc/BRIEF.md
# Serial Flash Erase and Program Sequencer

This block sits on the host side of a serial-peripheral link to a page-organised flash of 1024 pages of 264 bytes. A client hands it one request at a time: erase a single page, erase a block of eight pages, or load one of the two on-chip buffers and commit it to a page. The sequencer builds the 32-bit command header for that request and shifts it out MSB-first in SPI mode 0. For a program request it follows the header with the data bytes, taken one by one from a byte-wide valid/ready input. It then raises chip select, and the flash starts its self-timed operation on that rising edge.

After the command frame, the sequencer keeps chip select high for a minimum gap. It then reads the flash status in short frames until the ready bit appears. It reports the result with a single-cycle `done` pulse, or with an `error` pulse if the flash stays busy for a set number of polls. A new request is accepted only after this handshake and a further chip-select gap. The serial clock is the system clock divided by a parameter.

Top module: `flash_cmd_seq`

## Requirements
- R1: A request with kind 0 sends opcode 0x81, then five 0 bits, the ten page bits, then nine 0 bits, as one 32-clock frame MSB-first; chip select then rises.
- R2: A request with kind 1 sends opcode 0x50, five 0 bits, page bits 9..3, then twelve 0 bits; page bits 2..0 have no effect on the frame.
- R3: A request with kind 2 sends opcode 0x82 (buffer select 0) or 0x85 (buffer select 1), five 0 bits, the ten page bits and the nine offset bits. In the same frame it then sends the requested number of data bytes, each MSB-first.
- R4: The serial clock idles low whenever chip select is high. Each clock half lasts `SCLK_HALF` system cycles. MOSI changes only while the clock is low.
- R5: After every frame, chip select stays high for at least `CS_GAP` cycles. The command frame is followed by status frames of 16 clocks: opcode 0xD7 and then eight clocks that read the status byte.
- R6: Only bit 7 of the status byte is decoded, and 1 means ready. While it reads 0 the poll repeats. When it reads 1, `done` pulses for exactly one cycle, in the cycle chip select rises at the end of that poll.
- R7: If `MAX_POLLS` consecutive polls all read busy, `error` pulses for one cycle instead of `done`. It pulses in the cycle chip select rises at the end of the last poll, and `done` and `error` never pulse together.
- R8: `reqReady` is high only while the sequencer is idle with chip select high. A request is taken on `reqValid && reqReady`, and `reqReady` drops in the following cycle.
- R9: `dataReady` is high only inside a program frame between bytes, with chip select low and the clock low. A byte is taken on `dataValid && dataReady`, and the clock holds low while the sequencer waits for data.
- R10: A program request with a byte count of 0 sends only the 32-bit header before the poll phase.
- R11: After reset, chip select is high, the clock is low, `reqReady` is high, and `dataReady`, `done` and `error` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Request can be taken |
| reqKind | input | 2 | 0 page erase, 1 block erase, 2 buffer load then program |
| reqBufSel | input | 1 | Buffer choice for kind 2 |
| reqPage | input | 10 | Page number (block erase uses bits 9..3) |
| reqOffset | input | 9 | Starting byte within the buffer for kind 2 |
| reqCount | input | 9 | Number of data bytes for kind 2 |
| dataValid | input | 1 | Data byte offered |
| dataByte | input | 8 | Data byte |
| dataReady | output | 1 | Data byte can be taken |
| spiSclk | output | 1 | Serial clock, mode 0 |
| spiCsN | output | 1 | Chip select, active low |
| spiMosi | output | 1 | Serial data to the flash |
| spiMiso | input | 1 | Serial data from the flash |
| done | output | 1 | One-cycle pulse: flash reported ready |
| error | output | 1 | One-cycle pulse: poll limit reached while busy |

## Verification
The assertions assume the following about the inputs:
- Request fields stay steady while `reqValid` is high.
- `dataValid` and `dataByte` stay steady until the byte is taken.
- The flash model drives MISO only from falling serial-clock edges, so the value is settled before each rising edge.

The bench keeps to these assumptions by driving every input at the falling system-clock edge. It holds each offer until it observes the matching ready signal. Its flash model updates MISO only on serial-clock falls, and only when chip select drops.

// File: rtl/fcs_pkg.sv
`timescale 1ns/1ps
package fcs_pkg;
  localparam int PAGE_W    = 10;
  localparam int OFF_W     = 9;
  localparam int CNT_W     = 9;
  localparam int HDR_W     = 32;
  localparam int BLK_SHIFT = 3;

  localparam logic [7:0] OP_PAGE_ERASE  = 8'h81;
  localparam logic [7:0] OP_BLOCK_ERASE = 8'h50;
  localparam logic [7:0] OP_PROG_BUF1   = 8'h82;
  localparam logic [7:0] OP_PROG_BUF2   = 8'h85;

  typedef enum logic [1:0] {
    K_PAGE_ERASE  = 2'd0,
    K_BLOCK_ERASE = 2'd1,
    K_PROGRAM     = 2'd2
  } cmdKind_t;

  // strobes from control to datapath
  typedef struct packed {
    logic ldHdr;
    logic ldData;
    logic ldPoll;
    logic selCs;
  } dpCtrl_t;

  function automatic logic [HDR_W-1:0] buildHeader(
    input logic [1:0]        kind,
    input logic              bufSel,
    input logic [PAGE_W-1:0] page,
    input logic [OFF_W-1:0]  offset
  );
    logic [HDR_W-1:0] w;
    case (kind)
      K_BLOCK_ERASE: w = {OP_BLOCK_ERASE, 5'b0, page[PAGE_W-1:BLK_SHIFT], 12'b0};
      K_PROGRAM:     w = {(bufSel ? OP_PROG_BUF2 : OP_PROG_BUF1), 5'b0, page, offset};
      default:       w = {OP_PAGE_ERASE, 5'b0, page, 9'b0};
    endcase
    return w;
  endfunction
endpackage

// File: rtl/fcs_datapath.sv
`timescale 1ns/1ps
module fcs_datapath
  import fcs_pkg::*;
#(
  parameter int         SCLK_HALF = 2,
  parameter logic [7:0] POLL_OP   = 8'hD7
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCtrl_t          ctl,
  input  logic [HDR_W-1:0] hdrWord,
  input  logic [7:0]       dataByte,
  output logic             frameDone,
  output logic             statusReady,
  output logic             spiSclk,
  output logic             spiCsN,
  output logic             spiMosi,
  input  logic             spiMiso
);
  localparam int DIV_W = $clog2(SCLK_HALF + 1);
  localparam int BIT_W = $clog2(HDR_W + 1);

  logic [HDR_W-1:0] shiftQ;
  logic [BIT_W-1:0] bitsLeft;
  logic [DIV_W-1:0] divCnt;
  logic [7:0]       rxByte;
  logic             sclkQ;
  logic             csNQ;
  logic             active;
  logic             tick;

  assign active = (bitsLeft != '0);
  assign tick   = active && (divCnt == DIV_W'(SCLK_HALF - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftQ    <= '0;
      bitsLeft  <= '0;
      divCnt    <= '0;
      rxByte    <= '0;
      sclkQ     <= 1'b0;
      csNQ      <= 1'b1;
      frameDone <= 1'b0;
    end else begin
      csNQ      <= ~ctl.selCs;
      frameDone <= 1'b0;
      if (ctl.ldHdr) begin
        shiftQ   <= hdrWord;
        bitsLeft <= BIT_W'(HDR_W);
        divCnt   <= '0;
        sclkQ    <= 1'b0;
      end else if (ctl.ldData) begin
        shiftQ   <= {dataByte, {(HDR_W-8){1'b0}}};
        bitsLeft <= BIT_W'(8);
        divCnt   <= '0;
        sclkQ    <= 1'b0;
      end else if (ctl.ldPoll) begin
        shiftQ   <= {POLL_OP, {(HDR_W-8){1'b0}}};
        bitsLeft <= BIT_W'(16);
        divCnt   <= '0;
        sclkQ    <= 1'b0;
      end else if (tick) begin
        divCnt <= '0;
        if (!sclkQ) begin
          sclkQ  <= 1'b1;
          rxByte <= {rxByte[6:0], spiMiso};
        end else begin
          sclkQ    <= 1'b0;
          shiftQ   <= {shiftQ[HDR_W-2:0], 1'b0};
          bitsLeft <= bitsLeft - 1'b1;
          if (bitsLeft == BIT_W'(1)) frameDone <= 1'b1;
        end
      end else if (active) begin
        divCnt <= divCnt + 1'b1;
      end
    end
  end

  assign spiSclk     = sclkQ;
  assign spiCsN      = csNQ;
  assign spiMosi     = shiftQ[HDR_W-1];
  assign statusReady = rxByte[7];
endmodule

// File: rtl/fcs_ctrl.sv
`timescale 1ns/1ps
module fcs_ctrl
  import fcs_pkg::*;
#(
  parameter int CS_GAP    = 4,
  parameter int MAX_POLLS = 1000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [1:0]        reqKind,
  input  logic              reqBufSel,
  input  logic [PAGE_W-1:0] reqPage,
  input  logic [OFF_W-1:0]  reqOffset,
  input  logic [CNT_W-1:0]  reqCount,
  input  logic              dataValid,
  output logic              dataReady,
  input  logic              frameDone,
  input  logic              statusReady,
  output dpCtrl_t           ctl,
  output logic [HDR_W-1:0]  hdrWord,
  output logic              done,
  output logic              error
);
  localparam int GAP_W  = $clog2(CS_GAP + 1);
  localparam int POLL_W = $clog2(MAX_POLLS + 1);

  typedef enum logic [2:0] {S_IDLE, S_HDR, S_DWAIT, S_DSHIFT, S_GAP, S_POLL} state_t;

  state_t            state;
  logic [CNT_W-1:0]  remaining;
  logic [GAP_W-1:0]  gapCnt;
  logic [POLL_W-1:0] pollCnt;
  logic              pendPoll;
  logic              gapEnd;
  logic              lastPoll;

  assign hdrWord   = buildHeader(reqKind, reqBufSel, reqPage, reqOffset);
  assign reqReady  = (state == S_IDLE);
  assign dataReady = (state == S_DWAIT);
  assign gapEnd    = (gapCnt == GAP_W'(CS_GAP - 1));
  assign lastPoll  = (pollCnt == POLL_W'(MAX_POLLS - 1));

  always_comb begin
    ctl = '0;
    unique case (state)
      S_IDLE: begin
        ctl.ldHdr = reqValid;
        ctl.selCs = reqValid;
      end
      S_HDR, S_DSHIFT: ctl.selCs = !(frameDone && remaining == '0);
      S_DWAIT: begin
        ctl.selCs  = 1'b1;
        ctl.ldData = dataValid;
      end
      S_GAP: begin
        ctl.ldPoll = gapEnd && pendPoll;
        ctl.selCs  = gapEnd && pendPoll;
      end
      S_POLL:  ctl.selCs = !frameDone;
      default: ctl = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= S_IDLE;
      remaining <= '0;
      gapCnt    <= '0;
      pollCnt   <= '0;
      pendPoll  <= 1'b0;
      done      <= 1'b0;
      error     <= 1'b0;
    end else begin
      done  <= 1'b0;
      error <= 1'b0;
      unique case (state)
        S_IDLE: if (reqValid) begin
          state     <= S_HDR;
          remaining <= (reqKind == K_PROGRAM) ? reqCount : '0;
          pollCnt   <= '0;
          pendPoll  <= 1'b1;
        end
        S_HDR, S_DSHIFT: if (frameDone) begin
          if (remaining == '0) begin
            state  <= S_GAP;
            gapCnt <= '0;
          end else begin
            state <= S_DWAIT;
          end
        end
        S_DWAIT: if (dataValid) begin
          state     <= S_DSHIFT;
          remaining <= remaining - 1'b1;
        end
        S_GAP: begin
          if (gapEnd) state <= pendPoll ? S_POLL : S_IDLE;
          else        gapCnt <= gapCnt + 1'b1;
        end
        S_POLL: if (frameDone) begin
          state  <= S_GAP;
          gapCnt <= '0;
          if (statusReady) begin
            done     <= 1'b1;
            pendPoll <= 1'b0;
          end else if (lastPoll) begin
            error    <= 1'b1;
            pendPoll <= 1'b0;
          end else begin
            pollCnt <= pollCnt + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/flash_cmd_seq.sv
`timescale 1ns/1ps
module flash_cmd_seq
  import fcs_pkg::*;
#(
  parameter int         SCLK_HALF = 2,
  parameter int         CS_GAP    = 4,
  parameter int         MAX_POLLS = 1000,
  parameter logic [7:0] POLL_OP   = 8'hD7
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  output logic        reqReady,
  input  logic [1:0]  reqKind,
  input  logic        reqBufSel,
  input  logic [9:0]  reqPage,
  input  logic [8:0]  reqOffset,
  input  logic [8:0]  reqCount,
  input  logic        dataValid,
  input  logic [7:0]  dataByte,
  output logic        dataReady,
  output logic        spiSclk,
  output logic        spiCsN,
  output logic        spiMosi,
  input  logic        spiMiso,
  output logic        done,
  output logic        error
);
  dpCtrl_t          ctl;
  logic [HDR_W-1:0] hdrWord;
  logic             frameDone;
  logic             statusReady;

  fcs_ctrl #(.CS_GAP(CS_GAP), .MAX_POLLS(MAX_POLLS)) ctrlU (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqReady(reqReady), .reqKind(reqKind),
    .reqBufSel(reqBufSel), .reqPage(reqPage), .reqOffset(reqOffset),
    .reqCount(reqCount), .dataValid(dataValid), .dataReady(dataReady),
    .frameDone(frameDone), .statusReady(statusReady),
    .ctl(ctl), .hdrWord(hdrWord), .done(done), .error(error)
  );

  fcs_datapath #(.SCLK_HALF(SCLK_HALF), .POLL_OP(POLL_OP)) dpU (
    .clk(clk), .rstN(rstN), .ctl(ctl), .hdrWord(hdrWord),
    .dataByte(dataByte), .frameDone(frameDone), .statusReady(statusReady),
    .spiSclk(spiSclk), .spiCsN(spiCsN), .spiMosi(spiMosi), .spiMiso(spiMiso)
  );
endmodule

// File: rtl/fcs_chk.sv
`timescale 1ns/1ps
module fcs_chk #(
  parameter int CS_GAP = 4
) (
  input logic clk,
  input logic rstN,
  input logic spiCsN,
  input logic spiSclk,
  input logic spiMosi,
  input logic reqReady,
  input logic dataReady,
  input logic done,
  input logic error
);
  localparam int GAP_W = $clog2(CS_GAP + 1);
  logic [GAP_W-1:0] highCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                           highCnt <= GAP_W'(CS_GAP);
    else if (!spiCsN)                    highCnt <= '0;
    else if (highCnt != GAP_W'(CS_GAP))  highCnt <= highCnt + 1'b1;
  end

  // R4
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rstN) spiCsN |-> !spiSclk);
  // R4
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rstN) spiSclk |-> $stable(spiMosi));
  // R5
  cs_gap_chk: assert property (@(posedge clk) disable iff (!rstN) $fell(spiCsN) |-> highCnt == GAP_W'(CS_GAP));
  // R6
  done_edge_chk: assert property (@(posedge clk) disable iff (!rstN) done |-> $rose(spiCsN));
  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN) done |=> !done);
  // R7
  error_edge_chk: assert property (@(posedge clk) disable iff (!rstN) error |-> $rose(spiCsN));
  // R7
  excl_chk: assert property (@(posedge clk) disable iff (!rstN) !(done && error));
  // R8
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rstN) reqReady |-> spiCsN);
  // R9
  data_frame_chk: assert property (@(posedge clk) disable iff (!rstN) dataReady |-> (!spiCsN && !spiSclk));
endmodule

bind flash_cmd_seq fcs_chk #(.CS_GAP(CS_GAP)) chkU (
  .clk(clk), .rstN(rstN), .spiCsN(spiCsN), .spiSclk(spiSclk), .spiMosi(spiMosi),
  .reqReady(reqReady), .dataReady(dataReady), .done(done), .error(error)
);

// File: tb/flash_cmd_seq_test.sv
`timescale 1ns/1ps
module flash_cmd_seq_test;
  localparam int SCLK_HALF = 2;
  localparam int CS_GAP    = 4;
  localparam int MAX_POLLS = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [1:0] reqKind = 2'd0;
  logic reqBufSel = 1'b0;
  logic [9:0] reqPage = '0;
  logic [8:0] reqOffset = '0;
  logic [8:0] reqCount = '0;
  logic dataValid = 1'b0;
  logic [7:0] dataByte = '0;
  logic spiMiso = 1'b0;
  logic reqReady, dataReady, spiSclk, spiCsN, spiMosi, done, error;

  always #5 clk = ~clk;

  flash_cmd_seq #(.SCLK_HALF(SCLK_HALF), .CS_GAP(CS_GAP), .MAX_POLLS(MAX_POLLS)) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqKind(reqKind), .reqBufSel(reqBufSel), .reqPage(reqPage),
    .reqOffset(reqOffset), .reqCount(reqCount), .dataValid(dataValid),
    .dataByte(dataByte), .dataReady(dataReady), .spiSclk(spiSclk),
    .spiCsN(spiCsN), .spiMosi(spiMosi), .spiMiso(spiMiso),
    .done(done), .error(error)
  );

  typedef struct {
    logic [127:0] bits;
    int           len;
    string        tag;
  } frame_t;

  frame_t expQ[$];
  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int busyLeft = 0;
  logic [7:0] curStat = 8'h80;
  bit inFrame = 0;
  logic [127:0] obsBits = '0;
  int obsLen = 0;
  int firstRise = 0;

  task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) cyc++;

  // flash model: frame capture and status drive
  always @(negedge spiCsN) begin
    inFrame = 1;
    obsBits = '0;
    obsLen  = 0;
    curStat = (busyLeft > 0) ? 8'h7F : 8'h80;
    spiMiso = 1'b0;
  end

  always @(posedge spiSclk) if (inFrame) begin
    obsBits = {obsBits[126:0], spiMosi};
    obsLen++;
    if (obsLen == 1) firstRise = cyc;
    if (obsLen == 2) check((cyc - firstRise) == 2*SCLK_HALF, "R4 sclk period", cyc - firstRise, 2*SCLK_HALF);
  end

  always @(negedge spiSclk) if (inFrame)
    spiMiso = (obsLen >= 8 && obsLen < 16) ? curStat[15-obsLen] : 1'b0;

  // monitor: compare finished frames against the scoreboard
  always @(posedge spiCsN) if (inFrame) begin
    frame_t e;
    inFrame = 0;
    check(spiSclk == 1'b0, "R4 sclk idle", spiSclk, 0);
    if (obsLen == 16 && obsBits[15:8] == 8'hD7 && busyLeft > 0) busyLeft--;
    if (expQ.size() == 0) begin
      check(0, "R5 unexpected frame", obsBits, 0);
    end else begin
      e = expQ.pop_front();
      check(obsLen == e.len, {e.tag, " length"}, obsLen, e.len);
      check(obsBits == e.bits, e.tag, obsBits, e.bits);
    end
  end

  task automatic doReq(input logic [1:0] kind, input logic bs, input logic [9:0] pg,
                       input logic [8:0] off, input int n, input logic [31:0] dw,
                       input int busy, input bit expErr, input string tag);
    frame_t e;
    logic [31:0] hdr;
    int np;
    int waitN;
    case (kind)
      2'd1:    hdr = (32'h50 << 24) | (32'(pg >> 3) << 12);
      2'd2:    hdr = ((bs ? 32'h85 : 32'h82) << 24) | (32'(pg) << 9) | 32'(off);
      default: hdr = (32'h81 << 24) | (32'(pg) << 9);
    endcase
    e.bits = 128'(hdr);
    for (int i = 0; i < n; i++) e.bits = (e.bits << 8) | 128'(dw[31-8*i -: 8]);
    e.len = 32 + 8*n;
    e.tag = tag;
    expQ.push_back(e);
    np = expErr ? MAX_POLLS : busy + 1;
    for (int i = 0; i < np; i++) begin
      frame_t p;
      p.bits = 128'h0000_D700;
      p.len  = 16;
      p.tag  = "R5 poll";
      expQ.push_back(p);
    end
    busyLeft = expErr ? 100000 : busy;

    @(negedge clk);
    reqKind = kind; reqBufSel = bs; reqPage = pg; reqOffset = off; reqCount = 9'(n);
    reqValid = 1'b1;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    check(reqReady == 1'b0, "R8 ready drops", reqReady, 0);

    for (int i = 0; i < n; i++) begin
      for (int s = 0; s < 2*i + 1; s++) begin
        @(negedge clk);
        if (dataReady) check(spiSclk == 1'b0, "R9 clock held in stall", spiSclk, 0);
      end
      dataByte  = dw[31-8*i -: 8];
      dataValid = 1'b1;
      while (!dataReady) @(negedge clk);
      @(negedge clk);
      dataValid = 1'b0;
    end

    waitN = 0;
    while (!(done || error) && waitN < 40000) begin
      @(negedge clk);
      waitN++;
    end
    if (expErr) begin
      check(error == 1'b1 && done == 1'b0, "R7 error pulse", {done, error}, 2'b01);
    end else begin
      check(done == 1'b1 && error == 1'b0, "R6 done pulse", {done, error}, 2'b10);
    end
    check(spiCsN == 1'b1, "R6 cs high at result", spiCsN, 1);
    @(negedge clk);
    check(done == 1'b0 && error == 1'b0, "R6 single cycle pulse", {done, error}, 0);
    check(expQ.size() == 0, "R5 poll count", expQ.size(), 0);
    while (!reqReady) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    check(spiCsN == 1'b1 && spiSclk == 1'b0, "R11 bus idle", {spiCsN, spiSclk}, 2'b10);
    check(reqReady == 1'b1 && dataReady == 1'b0, "R11 handshakes", {reqReady, dataReady}, 2'b10);
    check(done == 1'b0 && error == 1'b0, "R11 result flags", {done, error}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    doReq(2'd0, 1'b0, 10'h2A5, 9'h1FF, 0, 32'h0, 2, 1'b0, "R1 page erase");
    doReq(2'd0, 1'b0, 10'h001, 9'h000, 0, 32'h0, 0, 1'b0, "R1 page erase low");
    doReq(2'd1, 1'b0, 10'h3FF, 9'h000, 0, 32'h0, 1, 1'b0, "R2 block erase");
    doReq(2'd1, 1'b0, 10'h0AB, 9'h000, 0, 32'h0, 0, 1'b0, "R2 block erase low bits");
    doReq(2'd2, 1'b0, 10'h005, 9'd263, 3, 32'hA53CFF00, 0, 1'b0, "R3 R9 program buf1");
    doReq(2'd2, 1'b1, 10'h3C3, 9'h0AA, 4, 32'h81_7E_00_C3, 1, 1'b0, "R3 program buf2");
    doReq(2'd2, 1'b1, 10'h200, 9'h001, 0, 32'h0, 0, 1'b0, "R10 program no data");
    doReq(2'd0, 1'b0, 10'h155, 9'h000, 0, 32'h0, 0, 1'b1, "R7 busy forever");
    doReq(2'd1, 1'b0, 10'h010, 9'h000, 0, 32'h0, 0, 1'b0, "R8 after error");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(negedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule